// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block is an eight-stage register that captures a byte in parallel and then sends it out one bit at a time. It lives entirely in one system-clock domain. The external shift clock and the clock-inhibit input are each passed through a two-flop synchronizer. The two synchronized levels are ORed, and the register advances one stage on each low-to-high change of that combined level. The two inputs therefore have interchangeable roles: either one can act as the clock while the other gates it.

An active-low load control overrides everything else. While it is low, every stage copies its parallel input on each system clock, whatever the shift clock, the inhibit and the serial input are doing. A combined-clock edge that arrives while the load control is low is used up and does not cause a later shift. The last stage drives the serial output and its complement. A synchronous active-high reset clears the stages and the edge-detect history.

Top module: `piso_gated_shreg`

## Requirements
- R1: After a synchronous reset all stages hold 0, so `ser_out` is 0 and `ser_out_n` is 1.
- R2: While `load_n` is 0, each stage k takes `par_in[k]` at every system clock. Stage 7 (`par_in[7]`) drives `ser_out`, so a loaded byte leaves most-significant bit first.
- R3: While `load_n` is 0, the shift clock, the inhibit and `ser_in` have no effect. A combined-clock rising edge seen during the load is dropped and does not shift after `load_n` returns to 1.
- R4: With `load_n` at 1 and `sinh` at 0, a rising `sclk` shifts once. Stage 0 takes `ser_in` and stage k takes stage k-1.
- R5: With `load_n` at 1 and `sclk` at 0, a rising `sinh` shifts once, exactly as a rising `sclk` does.
- R6: While the OR of `sclk` and `sinh` stays high, or when it falls, no shift occurs. For example, raising `sinh` while `sclk` is high does not shift.
- R7: `ser_out_n` is always the complement of `ser_out`.
- R8: One rising edge of the combined clock causes exactly one shift. The shift takes effect on the third system-clock edge after the input is first sampled high (two synchronizer stages, then the register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low parallel load, overrides shifting |
| par_in | input | 8 | Parallel data, bit k feeds stage k |
| ser_in | input | 1 | Serial data into stage 0 |
| sclk | input | 1 | Asynchronous shift clock |
| sinh | input | 1 | Asynchronous clock inhibit, interchangeable with sclk |
| ser_out | output | 1 | Last stage (stage 7) |
| ser_out_n | output | 1 | Complement of the last stage |

## Verification
Some properties are checked on every cycle:
- the complementary outputs always disagree;
- a cycle with `load_n` low puts `par_in[7]` on the output one cycle later;
- the output moves only on a shift pulse, and on that pulse it takes the previous stage 6;
- a shift pulse never lasts two cycles.

Other behaviours can only be shown by the bench scenarios:
- the whole bit order over eight shifts;
- how the inhibit and the clock trade roles, including inhibit rising while the clock is already high;
- a clock edge during a load being dropped, not deferred;
- serial data filling the register.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } piso_op_e;

    // Load has priority over any shift pulse in the same cycle.
    function automatic piso_op_e piso_pick_op(input logic load_n, input logic shift_pulse);
        if (!load_n)
            return OP_LOAD;
        else if (shift_pulse)
            return OP_SHIFT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_in};
        if (rst)
            chain_d = '0;
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/piso_edge_comb.sv
module piso_edge_comb (
    input  logic clk,
    input  logic rst,
    input  logic clk_s,
    input  logic inh_s,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     combined;

    always_comb begin
        combined = clk_s | inh_s;
        rise     = combined & ~st_q.prev;
        st_d.prev = rst ? 1'b0 : combined;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/piso_shift_core.sv
module piso_shift_core
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  piso_op_e         op,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stages
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD:  st_d.bits = par_in;
            OP_SHIFT: st_d.bits = {st_q.bits[WIDTH-2:0], ser_in};
            default:  st_d.bits = st_q.bits;
        endcase
        if (rst)
            st_d.bits = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stages = st_q.bits;
endmodule

// File: rtl/piso_gated_shreg.sv
module piso_gated_shreg
    import piso_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             sclk,
    input  logic             sinh,
    output logic             ser_out,
    output logic             ser_out_n
);
    localparam int NUM_ASYNC = 2;
    localparam int LAST      = WIDTH - 1;

    logic [NUM_ASYNC-1:0] raw_in;
    logic [NUM_ASYNC-1:0] synced;
    logic                 shift_pulse;
    piso_op_e             op;
    logic [WIDTH-1:0]     stages_w;

    assign raw_in = {sinh, sclk};

    for (genvar g = 0; g < NUM_ASYNC; g++) begin : g_sync
        piso_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .d_in  (raw_in[g]),
            .q_out (synced[g])
        );
    end

    piso_edge_comb u_edge (
        .clk   (clk),
        .rst   (rst),
        .clk_s (synced[0]),
        .inh_s (synced[1]),
        .rise  (shift_pulse)
    );

    assign op = piso_pick_op(load_n, shift_pulse);

    piso_shift_core #(.WIDTH(WIDTH)) u_core (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .par_in (par_in),
        .ser_in (ser_in),
        .stages (stages_w)
    );

    assign ser_out   = stages_w[LAST];
    assign ser_out_n = ~stages_w[LAST];
endmodule

// File: rtl/piso_gated_shreg_chk.sv
module piso_gated_shreg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             load_n,
    input logic [WIDTH-1:0] par_in,
    input logic             shift_pulse,
    input logic [WIDTH-1:0] stages_w,
    input logic             ser_out,
    input logic             ser_out_n
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (ser_out == 1'b0 && ser_out_n == 1'b1));

    // R7
    complement_chk: assert property (@(posedge clk) disable iff (rst) ser_out_n != ser_out);

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> ser_out == $past(par_in[WIDTH-1]));

    // R4
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && shift_pulse) |=> ser_out == $past(stages_w[WIDTH-2]));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && !shift_pulse) |=> $stable(ser_out));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> !shift_pulse);
endmodule

bind piso_gated_shreg piso_gated_shreg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_n      (load_n),
    .par_in      (par_in),
    .shift_pulse (shift_pulse),
    .stages_w    (stages_w),
    .ser_out     (ser_out),
    .ser_out_n   (ser_out_n)
);

// File: tb/piso_gated_shreg_tb.sv
`timescale 1ns/1ps
module piso_gated_shreg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_n = 1'b1;
    logic [7:0] par_in = '0;
    logic       ser_in = 1'b0;
    logic       sclk = 1'b0;
    logic       sinh = 1'b0;
    logic       ser_out, ser_out_n;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    logic [7:0] model = '0;

    always #2.5 clk = ~clk;

    piso_gated_shreg u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .par_in(par_in), .ser_in(ser_in),
        .sclk(sclk), .sinh(sinh), .ser_out(ser_out), .ser_out_n(ser_out_n)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_out(input string req);
        check_bit(req, ser_out, model[7]);
        check_bit({req, " R7"}, ser_out_n, ~model[7]);
    endtask

    // drive an edge on sclk (sel=0) or sinh (sel=1); model shift if expected
    task automatic drive_level(input bit sel, input logic lvl, input bit shifts);
        @(negedge clk);
        if (sel) sinh = lvl; else sclk = lvl;
        wait_n(4);
        if (shifts) model = {model[6:0], ser_in};
    endtask

    task automatic do_load(input logic [7:0] d);
        @(negedge clk);
        par_in = d; load_n = 1'b0;
        @(negedge clk);
        load_n = 1'b1;
        model = d;
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        wait_n(3);
        rst = 1'b0;
        model = '0;
        check_out("R1 reset");
        for (int i = 0; i < 3; i++) begin
            drive_level(0, 1'b1, 1'b1);
            drive_level(0, 1'b0, 1'b0);
            check_out("R1 zero after reset shift");
        end
    endtask

    task automatic t_load_shift(input logic [7:0] d);
        do_load(d);
        check_out("R2 load msb");
        ser_in = 1'b0;
        for (int i = 0; i < 7; i++) begin
            drive_level(0, 1'b1, 1'b1);
            check_out("R4 sclk shift");
            drive_level(0, 1'b0, 1'b0);
            check_out("R6 sclk fall no shift");
        end
    endtask

    task automatic t_inh_shift();
        do_load(8'b1001_0110);
        check_out("R2 load");
        for (int i = 0; i < 4; i++) begin
            drive_level(1, 1'b1, 1'b1);
            check_out("R5 sinh rise shift");
            drive_level(1, 1'b0, 1'b0);
            check_out("R5 sinh fall no shift");
        end
    endtask

    task automatic t_inh_while_high();
        do_load(8'b1010_0101);
        drive_level(0, 1'b1, 1'b1);
        check_out("R4 shift before inhibit");
        drive_level(1, 1'b1, 1'b0);
        check_out("R6 sinh rise while sclk high");
        drive_level(0, 1'b0, 1'b0);
        check_out("R6 sclk fall while sinh high");
        drive_level(1, 1'b0, 1'b0);
        check_out("R6 combined fall");
    endtask

    task automatic t_load_override();
        @(negedge clk);
        par_in = 8'b0111_1111; load_n = 1'b0; ser_in = 1'b1;
        model = par_in;
        wait_n(1);
        sclk = 1'b1;
        wait_n(5);
        ser_in = 1'b0;
        sinh = 1'b1;
        wait_n(5);
        check_out("R3 load held during edges");
        load_n = 1'b1;
        wait_n(4);
        check_out("R3 dropped edge, no late shift");
        drive_level(0, 1'b0, 1'b0);
        drive_level(1, 1'b0, 1'b0);
        ser_in = 1'b0;
        drive_level(0, 1'b1, 1'b1);
        check_out("R3 next shift after override");
        drive_level(0, 1'b0, 1'b0);
    endtask

    task automatic t_serial_fill();
        logic [7:0] pat = 8'b1100_1010;
        do_load(8'h00);
        for (int i = 7; i >= 0; i--) begin
            ser_in = pat[i];
            drive_level(1, 1'b1, 1'b1);
            drive_level(1, 1'b0, 1'b0);
        end
        check_out("R4 serial fill msb");
        ser_in = 1'b0;
        for (int i = 0; i < 7; i++) begin
            drive_level(0, 1'b1, 1'b1);
            drive_level(0, 1'b0, 1'b0);
            check_out("R4 serial fill order");
        end
    endtask

    task automatic t_latency();
        do_load(8'b1000_0000);
        @(negedge clk); sclk = 1'b1;
        @(negedge clk); @(negedge clk);
        check_bit("R8 no shift before third edge", ser_out, 1'b1);
        @(negedge clk);
        check_bit("R8 shift at third edge", ser_out, 1'b0);
        model = {model[6:0], ser_in};
        wait_n(6);
        check_out("R8 single shift per edge");
        drive_level(0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_load_shift(8'b1011_0010);
        t_load_shift(8'b0101_1101);
        t_inh_shift();
        t_inh_while_high();
        t_load_override();
        t_serial_fill();
        t_latency();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule